// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block is a bank of event counters that software programs through a plain register port. Each counter watches one of a set of event input lines. The line is chosen by an 8-bit code. The counter adds one on every clock in which that line is high. Counting needs two enables: a global run bit, and an enable bit that belongs to the counter.

The register port has one address. It takes a write strobe with 64 bits of write data, and it returns 64 bits of read data decoded combinationally from the address. Control registers use the low 32 bits of the data word. Each counter occupies a whole 64-bit word.

When a counter rolls over from all ones to zero, it sets a sticky overflow flag. The single interrupt output is the OR of every flag whose mask bit is 0. Software clears a flag by writing a 1 to its bit in a clear register. A read-only identifier register lets software tell the 16-counter, 48-bit build apart from the 8-counter, 64-bit build.

Top module: `evctr_unit`

## Requirements
- R1: After reset, the run bit and all per-counter enables are 0, every mask bit is 1, all counters and overflow flags are 0, and `irq_out` is 0.
- R2: A counter increases by exactly one at each clock edge at which its selected event line is high, run (bit 0 at 0x000) is 1 and its enable (bit idx at 0x004) is 1.
- R3: While run is 0, no counter changes, whatever the per-counter enables and event lines are.
- R4: Selector register k at 0x040+4k holds the codes of counters 4k to 4k+3, with counter idx at bits 8*(idx mod 4)+7 down to 8*(idx mod 4). A code equal to or above the number of event lines counts nothing.
- R5: Counter idx is read and written as one 64-bit word at 0x100+8*idx. With a 48-bit counter, bits 63:48 read as 0 and writes to them are dropped.
- R6: A write to a counter at the same edge as an increment loads the written value, and the increment is lost.
- R7: When a counter steps from all ones to zero, its overflow flag (bit idx of the status register at 0x00C) becomes 1 and stays 1. Writes to 0x00C are ignored.
- R8: Writing to the clear register at 0x010 clears every flag whose bit is 1 and leaves the others unchanged. If a flag is set and cleared at the same edge, it ends up 1. The clear register reads as 0.
- R9: `irq_out` is 1 exactly when some overflow flag is 1 and its bit in the mask register at 0x008 is 0. A mask bit of 1 blocks that flag.
- R10: The register at 0x014 returns the parameter `VERSION_ID` and ignores writes. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_EVT | Event lines, one bit per event code |
| acc_addr | input | 12 | Register byte address |
| acc_wr | input | 1 | Write strobe, write takes effect at the clock edge |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data for `acc_addr`, combinational |
| irq_out | output | 1 | Unmasked overflow interrupt |

## Verification
Every result of this block is due one clock edge after its cause. A register write, a counted event, a wrap flag and a clear all appear one edge later. Read data and `irq_out` are then combinational from the updated state, so they are valid well before the next edge. The bench drives its inputs just after each falling edge. A behavioural model updates at each rising edge from the inputs held across that edge. At the following falling edge, the bench compares the read data for the current address and the interrupt line against the model. Each comparison therefore falls exactly one edge after the stimulus that caused it.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
  localparam int AW = 12;
  localparam logic [AW-1:0] ADDR_RUN   = 12'h000;
  localparam logic [AW-1:0] ADDR_EN    = 12'h004;
  localparam logic [AW-1:0] ADDR_MASK  = 12'h008;
  localparam logic [AW-1:0] ADDR_STAT  = 12'h00C;
  localparam logic [AW-1:0] ADDR_CLR   = 12'h010;
  localparam logic [AW-1:0] ADDR_VER   = 12'h014;
  localparam logic [AW-1:0] ADDR_SEL0  = 12'h040;
  localparam logic [AW-1:0] ADDR_CNT0  = 12'h100;

  // byte address of selector word k (four 8-bit codes per word)
  function automatic logic [AW-1:0] sel_addr(input int k);
    return ADDR_SEL0 + AW'(4 * k);
  endfunction

  // byte address of the 64-bit counter slot idx
  function automatic logic [AW-1:0] cnt_addr(input int idx);
    return ADDR_CNT0 + AW'(8 * idx);
  endfunction
endpackage

// File: rtl/evctr_slice.sv
module evctr_slice #(
  parameter int CTR_W   = 48,
  parameter int NUM_EVT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [7:0]         code,
  input  logic               count_on,
  input  logic               wr_hit,
  input  logic [CTR_W-1:0]   wr_val,
  output logic [CTR_W-1:0]   count,
  output logic               wrap
);
  localparam int SPACE = 256;

  logic [SPACE-1:0] evt_pad;
  logic             evt_sel;
  logic             inc;

  generate
    if (NUM_EVT < SPACE) begin : g_pad
      assign evt_pad = {{(SPACE-NUM_EVT){1'b0}}, evt_in};
    end else begin : g_full
      assign evt_pad = evt_in[SPACE-1:0];
    end
  endgenerate

  function automatic logic [CTR_W-1:0] bump(input logic [CTR_W-1:0] v);
    return v + 1'b1;
  endfunction

  assign evt_sel = evt_pad[code];
  assign inc     = count_on & evt_sel;
  assign wrap    = inc & ~wr_hit & (count == {CTR_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (wr_hit) count <= wr_val;
    else if (inc)    count <= bump(count);
  end

  assert_wr_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> count == $past(wr_val));
  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_hit) |=> count == $past(count) + 1'b1);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_on && !wr_hit) |=> $stable(count));
endmodule

// File: rtl/evctr_irq.sv
module evctr_irq #(
  parameter int NUM_CTR = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] wrap,
  input  logic [NUM_CTR-1:0] clr,
  input  logic [NUM_CTR-1:0] mask,
  output logic [NUM_CTR-1:0] stat,
  output logic               irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr) | wrap;
  end

  assign irq = |(stat & ~mask);

  assert_wrap_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap != '0) |=> ((stat & $past(wrap)) == $past(wrap)));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~wrap) != '0) |=> ((stat & $past(clr & ~wrap)) == '0));
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == {NUM_CTR{1'b1}}) |-> !irq);
endmodule

// File: rtl/evctr_regs.sv
module evctr_regs
  import evctr_pkg::*;
#(
  parameter int          NUM_CTR    = 8,
  parameter int          CTR_W      = 48,
  parameter logic [31:0] VERSION_ID = 32'h0000_0200
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 acc_addr,
  input  logic                          acc_wr,
  input  logic [63:0]                   acc_wdata,
  input  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_vals,
  input  logic [NUM_CTR-1:0]            stat,
  output logic                          run,
  output logic [NUM_CTR-1:0]            en,
  output logic [NUM_CTR-1:0]            mask,
  output logic [NUM_CTR-1:0][7:0]       sel,
  output logic [NUM_CTR-1:0]            cnt_wr,
  output logic [NUM_CTR-1:0]            clr,
  output logic [63:0]                   rdata
);
  localparam int NSEL  = (NUM_CTR + 3) / 4;
  localparam int NSLOT = NSEL * 4;

  logic [NSLOT-1:0][7:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      en    <= '0;
      mask  <= '1;
      sel_q <= '0;
    end else if (acc_wr) begin
      if (acc_addr == ADDR_RUN)  run  <= acc_wdata[0];
      if (acc_addr == ADDR_EN)   en   <= acc_wdata[NUM_CTR-1:0];
      if (acc_addr == ADDR_MASK) mask <= acc_wdata[NUM_CTR-1:0];
      for (int i = 0; i < NUM_CTR; i++) begin
        if (acc_addr == sel_addr(i / 4)) sel_q[i] <= acc_wdata[8*(i%4) +: 8];
      end
    end
  end

  assign sel = sel_q[NUM_CTR-1:0];

  always_comb begin
    for (int i = 0; i < NUM_CTR; i++) begin
      cnt_wr[i] = acc_wr && (acc_addr == cnt_addr(i));
    end
    clr = (acc_wr && acc_addr == ADDR_CLR) ? acc_wdata[NUM_CTR-1:0] : '0;
  end

  always_comb begin
    rdata = '0;
    if (acc_addr == ADDR_RUN)  rdata[0]           = run;
    if (acc_addr == ADDR_EN)   rdata[NUM_CTR-1:0] = en;
    if (acc_addr == ADDR_MASK) rdata[NUM_CTR-1:0] = mask;
    if (acc_addr == ADDR_STAT) rdata[NUM_CTR-1:0] = stat;
    if (acc_addr == ADDR_VER)  rdata[31:0]        = VERSION_ID;
    for (int k = 0; k < NSEL; k++) begin
      if (acc_addr == sel_addr(k)) rdata[31:0] = sel_q[4*k +: 4];
    end
    for (int i = 0; i < NUM_CTR; i++) begin
      if (acc_addr == cnt_addr(i)) rdata[CTR_W-1:0] = cnt_vals[i];
    end
  end
endmodule

// File: rtl/evctr_unit.sv
module evctr_unit
  import evctr_pkg::*;
#(
  parameter int          NUM_CTR    = 8,
  parameter int          CTR_W      = 48,
  parameter int          NUM_EVT    = 32,
  parameter logic [31:0] VERSION_ID = 32'h0000_0200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [11:0]        acc_addr,
  input  logic               acc_wr,
  input  logic [63:0]        acc_wdata,
  output logic [63:0]        acc_rdata,
  output logic               irq_out
);
  logic                          run;
  logic [NUM_CTR-1:0]            en, mask, stat, clr, cnt_wr, wrap;
  logic [NUM_CTR-1:0][7:0]       sel;
  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_vals;

  evctr_regs #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .VERSION_ID(VERSION_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .cnt_vals(cnt_vals), .stat(stat), .run(run),
    .en(en), .mask(mask), .sel(sel), .cnt_wr(cnt_wr), .clr(clr),
    .rdata(acc_rdata)
  );

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      evctr_slice #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT)) u_slice (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .code(sel[i]),
        .count_on(run & en[i]), .wr_hit(cnt_wr[i]),
        .wr_val(acc_wdata[CTR_W-1:0]), .count(cnt_vals[i]), .wrap(wrap[i])
      );
    end
  endgenerate

  evctr_irq #(.NUM_CTR(NUM_CTR)) u_irq (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .clr(clr), .mask(mask),
    .stat(stat), .irq(irq_out)
  );
endmodule

// File: tb/evctr_unit_tb.sv
module evctr_unit_tb;
  localparam int NC = 8;
  localparam int NE = 32;
  localparam logic [31:0] VER = 32'h0000_0200;
  localparam longint unsigned WMASK = (64'd1 << 48) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt_in = '0;
  logic [11:0]   acc_addr = '0;
  logic          acc_wr = 1'b0;
  logic [63:0]   acc_wdata = '0;
  logic [63:0]   acc_rdata;
  logic          irq_out;

  evctr_unit #(.NUM_CTR(NC), .CTR_W(48), .NUM_EVT(NE), .VERSION_ID(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .acc_addr(acc_addr),
    .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    chk_on = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference state
  bit              m_run;
  bit [NC-1:0]     m_en, m_mask, m_stat;
  bit [7:0]        m_sel [NC];
  longint unsigned m_cnt [NC];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_en = '0; m_mask = '1; m_stat = '0;
      for (int i = 0; i < NC; i++) begin m_sel[i] = 0; m_cnt[i] = 0; end
    end else begin
      bit [NC-1:0] wrapv;
      bit [NC-1:0] clrv;
      wrapv = '0; clrv = '0;
      for (int i = 0; i < NC; i++) begin
        bit hit;
        hit = m_run && m_en[i] && (m_sel[i] < NE) && evt_in[m_sel[i] % NE];
        if (acc_wr && acc_addr == 12'h100 + 12'(8*i)) m_cnt[i] = acc_wdata & WMASK;
        else if (hit) begin
          if (m_cnt[i] == WMASK) begin m_cnt[i] = 0; wrapv[i] = 1; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (acc_wr) begin
        case (acc_addr)
          12'h000: m_run  = acc_wdata[0];
          12'h004: m_en   = acc_wdata[NC-1:0];
          12'h008: m_mask = acc_wdata[NC-1:0];
          12'h010: clrv   = acc_wdata[NC-1:0];
          default: ;
        endcase
        for (int i = 0; i < NC; i++)
          if (acc_addr == 12'h040 + 12'(4*(i/4))) m_sel[i] = acc_wdata[8*(i%4) +: 8];
      end
      m_stat = (m_stat & ~clrv) | wrapv;
    end
  end

  function automatic logic [63:0] mread(input logic [11:0] a);
    logic [63:0] r;
    r = '0;
    case (a)
      12'h000: r[0] = m_run;
      12'h004: r[NC-1:0] = m_en;
      12'h008: r[NC-1:0] = m_mask;
      12'h00C: r[NC-1:0] = m_stat;
      12'h014: r[31:0] = VER;
      default: ;
    endcase
    for (int i = 0; i < NC; i++) begin
      if (a == 12'h040 + 12'(4*(i/4))) r[8*(i%4) +: 8] = m_sel[i];
      if (a == 12'h100 + 12'(8*i)) r = m_cnt[i];
    end
    return r;
  endfunction

  // compare once per cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && chk_on && !done) begin
      logic [63:0] exp_d;
      exp_d = mread(acc_addr);
      total++;
      if (acc_rdata !== exp_d) begin
        bad++;
        $display("FAIL %s addr=%h rdata actual=%h expected=%h", tag, acc_addr, acc_rdata, exp_d);
      end
      total++;
      if (irq_out !== |(m_stat & ~m_mask)) begin
        bad++;
        $display("FAIL %s/R9 irq actual=%b expected=%b", tag, irq_out, |(m_stat & ~m_mask));
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    acc_wr = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk); #1;
    acc_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a);
    acc_addr = a;
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1; chk_on = 1;
    // R1 reset values
    tag = "R1";
    rd(12'h000); rd(12'h004); rd(12'h008); rd(12'h00C);
    for (int i = 0; i < NC; i++) rd(12'h100 + 12'(8*i));
    // R10 identifier and unmapped reads
    tag = "R10";
    rd(12'h014); wr(12'h014, 64'hDEAD); rd(12'h014); rd(12'h0F0);
    // R4 selectors: counter1 gets code 200 (beyond event lines)
    tag = "R4";
    wr(12'h040, {32'h0, 8'd5, 8'd3, 8'd200, 8'd1});
    wr(12'h044, {32'h0, 8'd7, 8'd7, 8'd2, 8'd9});
    rd(12'h040); rd(12'h044);
    // R2 counting with varied event patterns
    tag = "R2";
    wr(12'h004, 64'hFF); wr(12'h000, 64'h1);
    for (int c = 0; c < 24; c++) begin
      evt_in = NE'(32'h1357_9BDF * (c + 1)) ^ NE'(c << 3);
      rd(12'h100 + 12'(8*(c % NC)));
    end
    tag = "R4";
    evt_in = '1;
    rd(12'h108); rd(12'h108);
    // R3 run bit clear
    tag = "R3";
    wr(12'h000, 64'h0);
    for (int c = 0; c < 10; c++) begin
      evt_in = ~evt_in; rd(12'h100 + 12'(8*(c % NC)));
    end
    // R5 upper bits dropped
    tag = "R5";
    wr(12'h110, 64'hFFFF_FFFF_FFFF_FFF0); rd(12'h110);
    wr(12'h128, 64'hABCD_0000_0000_0005); rd(12'h128);
    // R6 write beats increment
    tag = "R6";
    evt_in = '1; wr(12'h000, 64'h1);
    wr(12'h100, 64'h1234); rd(12'h100); rd(12'h100);
    // R7 wrap sets flag, status writes ignored
    tag = "R7";
    for (int c = 0; c < 20; c++) rd(c[0] ? 12'h00C : 12'h110);
    wr(12'h00C, 64'h0); rd(12'h00C);
    // R9 mask
    tag = "R9";
    wr(12'h008, 64'hFB); rd(12'h00C); wr(12'h008, 64'hFF); rd(12'h008);
    wr(12'h008, 64'h00); rd(12'h00C);
    // R8 clear: zero write, single bit, same-edge set and clear
    tag = "R8";
    wr(12'h010, 64'h0); rd(12'h00C);
    wr(12'h010, 64'h04); rd(12'h00C); rd(12'h010);
    wr(12'h120, WMASK);
    wr(12'h010, 64'h10); rd(12'h00C); rd(12'h120);
    wr(12'h010, 64'hFF); rd(12'h00C);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule